// File: doc/BRIEF.md
# Neighbourhood Block Pixel Loader

This block feeds one image block, together with a border of neighbouring pixels of depth `R`, into a two-dimensional array of `NW` by `NH` processing nodes. Pixels arrive one at a time on a valid/ready input. A serial-to-parallel stage collects them into rows of `W = NW + 2R` pixels. Each completed row enters the top of a chain of FIFO registers and pushes the rows already held one step to the south. Data moves through the chain in the vertical direction only.

The FIFO registers are owned by the nodes, and the number each node owns depends on where it sits. A corner node holds an `(R+1)` by `(R+1)` patch. A node on the north or south edge holds a column of `R+1` registers. A node on the west or east edge holds a row of `R+1` registers. An interior node holds a single register for its centre pixel. When the chain holds a complete block, a copy command moves every FIFO register into the node registers in one cycle. The chain can then take the next block at once, while the nodes work on the current one.

Results travel the other way. A load strobe captures one result pixel per node into a parallel-to-serial register. The pixels then leave one per cycle, each marked by a valid strobe.

Top module: `nbl_block_loader`

## Requirements
- R1: After reset, `pix_ready` is 1, `blk_full` is 0, `res_valid` is 0 and every pixel of `node_px` is 0.
- R2: A block holds exactly `W*H` pixels, with `W = NW+2R` and `H = NH+2R`. With `R = 0` this is `NW*NH`.
- R3: Placement order. The raster index of a pixel is `row*W + col`, where row 0 is the north row, col 0 is the west column, and index 0 occupies the least significant `DW` bits of `node_px`. After a copy, the k-th pixel accepted in the block (counting from 0) appears at raster index `W*H-1-k`. The sender must therefore send the last pixel of the block first.
- R4: `blk_full` rises in the cycle after the pixel that completes the block is accepted, and not before. While `blk_full` is 1, `pix_ready` is 0, and any pixel offered is dropped.
- R5: A `copy_cmd` that arrives while `blk_full` is 0 has no effect. `node_px` keeps its value, and the count of pixels accepted is not reset.
- R6: A `copy_cmd` that arrives while `blk_full` is 1 has three effects in the next cycle: `node_px` shows the new block, `blk_full` is 0, and `pix_ready` is 1.
- R7: `node_px` changes only in the cycle after an accepted copy. Pixels still moving through the chain do not disturb it.
- R8: A `res_load` that arrives while `res_valid` is 0 captures `res_data`. For the next `NW*NH` cycles, `res_valid` is 1 and `res_pix` presents node index 0 (the least significant `DW` bits) first, then the following indices in ascending order. After that, `res_valid` returns to 0.
- R9: A `res_load` that arrives while `res_valid` is 1 is ignored, and the stream in progress continues unchanged.
- R10: Idle cycles between accepted pixels (`pix_valid` held low) do not change where the pixels land.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Input pixel is present |
| pix_data | input | DW | Input pixel value |
| pix_ready | output | 1 | Loader can accept a pixel |
| blk_full | output | 1 | Chain holds a complete block |
| copy_cmd | input | 1 | Global command to copy the chain into the node registers |
| node_px | output | W*H*DW | Node registers in raster order |
| res_load | input | 1 | Capture result pixels for serial unload |
| res_data | input | NW*NH*DW | One result pixel per node, node index 0 in the least significant bits |
| res_valid | output | 1 | `res_pix` carries a result pixel |
| res_pix | output | DW | Serial result pixel |

## Verification
The assertions take for granted that the sender honours `pix_ready`. They also take for granted that `copy_cmd` is the only thing that ends a block, so a separate count of accepted pixels since the last accepted copy must agree with `blk_full`. The stimulus offers a pixel while the block is full only to test that it is dropped. It pulses `copy_cmd` in the middle of a block and `res_load` in the middle of an unload only to test that each is ignored. Every other pixel is offered while `pix_ready` is high, with and without idle gaps between pixels.

// File: rtl/nbl_pkg.sv
package nbl_pkg;
  // Columns (or rows) of chain registers owned by the node at position idx of n.
  function automatic int span(input int idx, input int n, input int r);
    int s;
    s = 1;
    if (idx == 0) s = s + r;
    if (idx == n - 1) s = s + r;
    return s;
  endfunction

  // First chain column (or row) owned by the node at position idx.
  function automatic int first(input int idx, input int r);
    return (idx == 0) ? 0 : idx + r;
  endfunction
endpackage

// File: rtl/nbl_row_stage.sv
module nbl_row_stage #(
  parameter int DW = 8,
  parameter int W  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic [DW-1:0]   pix_i,
  output logic            push_o,
  output logic [W*DW-1:0] row_o
);
  localparam int CLW = $clog2(W);
  localparam logic [CLW-1:0] LASTCOL = CLW'(W - 1);

  logic [W-1:1][DW-1:0] stg_q, stg_d;
  logic [CLW-1:0]       col_q, col_d;

  always_comb begin
    stg_d    = stg_q;
    stg_d[1] = pix_i;
    for (int c = 2; c < W; c++) stg_d[c] = stg_q[c-1];
    col_d = (col_q == LASTCOL) ? '0 : col_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
      col_q <= '0;
    end else if (advance) begin
      stg_q <= stg_d;
      col_q <= col_d;
    end
  end

  assign push_o = advance && (col_q == LASTCOL);

  // The pixel arriving now is the west end of the row; earlier arrivals lie east.
  always_comb begin
    row_o[DW-1:0] = pix_i;
    for (int c = 1; c < W; c++) row_o[c*DW +: DW] = stg_q[c];
  end
endmodule

// File: rtl/nbl_node_fifo.sv
module nbl_node_fifo #(
  parameter int DW = 8,
  parameter int LW = 1,
  parameter int LH = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic [LW*DW-1:0]   north_i,
  output logic [LH*LW*DW-1:0] fifo_o
);
  logic [LH-1:0][LW*DW-1:0] fifo_q, fifo_d;

  always_comb begin
    fifo_d    = fifo_q;
    fifo_d[0] = north_i;
    for (int r = 1; r < LH; r++) fifo_d[r] = fifo_q[r-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fifo_q <= '0;
    else if (shift_en) fifo_q <= fifo_d;
  end

  assign fifo_o = fifo_q;
endmodule

// File: rtl/nbl_unload.sv
module nbl_unload #(
  parameter int DW = 8,
  parameter int N  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [N*DW-1:0] data_i,
  output logic            valid_o,
  output logic [DW-1:0]   pix_o
);
  localparam int LCW = $clog2(N + 1);

  logic [N*DW-1:0] sh_q, sh_d;
  logic [LCW-1:0]  left_q, left_d;
  logic            busy, take, step;

  assign busy = (left_q != '0);
  assign take = load && !busy;
  assign step = take || busy;

  always_comb begin
    if (take) begin
      sh_d   = data_i;
      left_d = LCW'(N);
    end else begin
      sh_d   = sh_q >> DW;
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (step) begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end

  assign valid_o = busy;
  assign pix_o   = sh_q[DW-1:0];
endmodule

// File: rtl/nbl_block_loader.sv
module nbl_block_loader #(
  parameter int NW = 4,
  parameter int NH = 3,
  parameter int R  = 1,
  parameter int DW = 8,
  localparam int W    = NW + 2 * R,
  localparam int H    = NH + 2 * R,
  localparam int TOT  = W * H,
  localparam int NRES = NW * NH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic [DW-1:0]     pix_data,
  output logic              pix_ready,
  output logic              blk_full,
  input  logic              copy_cmd,
  output logic [TOT*DW-1:0] node_px,
  input  logic              res_load,
  input  logic [NRES*DW-1:0] res_data,
  output logic              res_valid,
  output logic [DW-1:0]     res_pix
);
  localparam int CW = $clog2(TOT + 1);
  localparam logic [CW-1:0] TOTC = CW'(TOT);

  logic [CW-1:0]            cnt_q, cnt_d;
  logic                     accept, copy_en, push;
  logic [W*DW-1:0]          row_top;
  logic [NH-1:0][W*DW-1:0]  bnd;
  logic [TOT*DW-1:0]        fifo_flat;
  logic [TOT*DW-1:0]        node_q, node_d;

  assign blk_full  = (cnt_q == TOTC);
  assign pix_ready = !blk_full;
  assign accept    = pix_valid && !blk_full;
  assign copy_en   = copy_cmd && blk_full;

  always_comb begin
    cnt_d = cnt_q;
    if (copy_en)     cnt_d = '0;
    else if (accept) cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    node_d = copy_en ? fifo_flat : node_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      node_q <= '0;
    end else begin
      if (copy_en || accept) cnt_q <= cnt_d;
      if (copy_en)           node_q <= node_d;
    end
  end

  assign node_px = node_q;

  nbl_row_stage #(.DW(DW), .W(W)) u_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .advance(accept),
    .pix_i  (pix_data),
    .push_o (push),
    .row_o  (row_top)
  );

  assign bnd[0] = row_top;

  for (genvar gj = 0; gj < NH; gj++) begin : g_row
    for (genvar gi = 0; gi < NW; gi++) begin : g_col
      localparam int LW = nbl_pkg::span(gi, NW, R);
      localparam int LH = nbl_pkg::span(gj, NH, R);
      localparam int XO = nbl_pkg::first(gi, R);
      localparam int YO = nbl_pkg::first(gj, R);

      logic [LH*LW*DW-1:0] cell_fifo;

      nbl_node_fifo #(.DW(DW), .LW(LW), .LH(LH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(push),
        .north_i (bnd[gj][XO*DW +: LW*DW]),
        .fifo_o  (cell_fifo)
      );

      if (gj < NH - 1) begin : g_pass
        assign bnd[gj+1][XO*DW +: LW*DW] = cell_fifo[(LH-1)*LW*DW +: LW*DW];
      end

      for (genvar lr = 0; lr < LH; lr++) begin : g_map
        assign fifo_flat[((YO+lr)*W + XO)*DW +: LW*DW] = cell_fifo[lr*LW*DW +: LW*DW];
      end
    end
  end

  nbl_unload #(.DW(DW), .N(NRES)) u_unload (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (res_load),
    .data_i (res_data),
    .valid_o(res_valid),
    .pix_o  (res_pix)
  );
endmodule

// File: rtl/nbl_block_loader_chk.sv
module nbl_block_loader_chk #(
  parameter int NW = 4,
  parameter int NH = 3,
  parameter int R  = 1,
  parameter int DW = 8
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic                                  pix_valid,
  input logic                                  pix_ready,
  input logic                                  blk_full,
  input logic                                  copy_cmd,
  input logic [(NW+2*R)*(NH+2*R)*DW-1:0]       node_px,
  input logic                                  res_load,
  input logic                                  res_valid
);
  localparam int TOT  = (NW + 2 * R) * (NH + 2 * R);
  localparam int NRES = NW * NH;

  int unsigned acc_q;
  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 0;
      run_q <= 0;
    end else begin
      if (copy_cmd && acc_q == TOT) acc_q <= 0;
      else if (pix_valid && pix_ready) acc_q <= acc_q + 1;
      run_q <= res_valid ? run_q + 1 : 0;
    end
  end

  a_r4_full_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
    blk_full == (acc_q == TOT));

  a_r4_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    blk_full && !copy_cmd |=> blk_full);

  a_r6_copy_frees: assert property (@(posedge clk) disable iff (!rst_n)
    blk_full && copy_cmd |=> pix_ready && !blk_full);

  a_r7_node_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(blk_full && copy_cmd) |=> $stable(node_px));

  a_r8_unload_starts: assert property (@(posedge clk) disable iff (!rst_n)
    res_load && !res_valid |=> res_valid);

  a_r9_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> run_q < NRES);
endmodule

bind nbl_block_loader nbl_block_loader_chk #(.NW(NW), .NH(NH), .R(R), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pix_valid(pix_valid),
  .pix_ready(pix_ready),
  .blk_full (blk_full),
  .copy_cmd (copy_cmd),
  .node_px  (node_px),
  .res_load (res_load),
  .res_valid(res_valid)
);

// File: tb/nbl_block_loader_test.sv
`timescale 1ns/1ps
module nbl_block_loader_test;
  localparam int DW = 8;
  localparam int NW = 4, NH = 3, R = 1;
  localparam int W = NW + 2 * R, H = NH + 2 * R, TOT = W * H, NRES = NW * NH;
  localparam int NW0 = 2, NH0 = 3, TOT0 = NW0 * NH0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic pv = 1'b0, cp = 1'b0, rl = 1'b0;
  logic [DW-1:0] pd = '0;
  logic pr, full, rv;
  logic [TOT*DW-1:0] npx;
  logic [NRES*DW-1:0] rd = '0;
  logic [DW-1:0] rp;

  logic pv0 = 1'b0, cp0 = 1'b0, rl0 = 1'b0;
  logic [DW-1:0] pd0 = '0;
  logic pr0, full0, rv0;
  logic [TOT0*DW-1:0] npx0;
  logic [TOT0*DW-1:0] rd0 = '0;
  logic [DW-1:0] rp0;

  nbl_block_loader #(.NW(NW), .NH(NH), .R(R), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pv), .pix_data(pd), .pix_ready(pr),
    .blk_full(full), .copy_cmd(cp), .node_px(npx), .res_load(rl),
    .res_data(rd), .res_valid(rv), .res_pix(rp));

  nbl_block_loader #(.NW(NW0), .NH(NH0), .R(0), .DW(DW)) uut0 (
    .clk(clk), .rst_n(rst_n), .pix_valid(pv0), .pix_data(pd0), .pix_ready(pr0),
    .blk_full(full0), .copy_cmd(cp0), .node_px(npx0), .res_load(rl0),
    .res_data(rd0), .res_valid(rv0), .res_pix(rp0));

  int checks = 0;
  int fails = 0;

  function automatic logic [DW-1:0] pval(input int b, input int idx);
    return DW'((b * 37 + idx * 5 + 3) % 256);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Sends pixels k0..k1 of block b, last raster pixel first (R3).
  task automatic send_range(input int b, input int k0, input int k1, input bit gaps);
    for (int k = k0; k <= k1; k++) begin
      @(negedge clk);
      if (gaps && (k % 3 == 2)) begin
        pv = 1'b0;
        @(negedge clk);
      end
      pv = 1'b1;
      pd = pval(b, TOT - 1 - k);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    pv = 1'b0;
  endtask

  task automatic copy_pulse();
    @(negedge clk);
    cp = 1'b1;
    @(negedge clk);
    cp = 1'b0;
  endtask

  task automatic check_nodes(input int b, input string req);
    for (int i = 0; i < TOT; i++)
      chk(npx[i*DW +: DW] == pval(b, i), req, int'(npx[i*DW +: DW]), int'(pval(b, i)));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pr == 1'b1, "R1 ready", int'(pr), 1);
    chk(full == 1'b0, "R1 full", int'(full), 0);
    chk(rv == 1'b0, "R1 res_valid", int'(rv), 0);
    chk(npx == '0, "R1 node_px zero", int'(npx[DW-1:0]), 0);

    // Block 0: all but the last pixel, then the last
    send_range(0, 0, TOT - 2, 1'b0);
    idle();
    chk(full == 1'b0, "R4 not full one short", int'(full), 0);
    send_range(0, TOT - 1, TOT - 1, 1'b0);
    idle();
    chk(full == 1'b1, "R2 full at block total", int'(full), 1);
    chk(pr == 1'b0, "R4 ready low when full", int'(pr), 0);
    chk(npx == '0, "R7 node_px untouched before copy", int'(npx[DW-1:0]), 0);

    // Offer a pixel while full: must be dropped (R4)
    @(negedge clk);
    pv = 1'b1;
    pd = 8'hEE;
    @(negedge clk);
    pv = 1'b0;
    chk(full == 1'b1, "R4 still full after dropped pixel", int'(full), 1);

    copy_pulse();
    chk(pr == 1'b1, "R6 ready after copy", int'(pr), 1);
    chk(full == 1'b0, "R6 full clears after copy", int'(full), 0);
    check_nodes(0, "R3 placement block 0");

    // Block 1 with a stray copy mid-block (R5) and idle gaps (R10)
    send_range(1, 0, 9, 1'b0);
    idle();
    copy_pulse();
    check_nodes(0, "R5 early copy ignored");
    send_range(1, 10, TOT - 2, 1'b1);
    idle();
    chk(full == 1'b0, "R5 count kept across ignored copy", int'(full), 0);
    send_range(1, TOT - 1, TOT - 1, 1'b0);
    idle();
    chk(full == 1'b1, "R2 full block 1", int'(full), 1);
    check_nodes(0, "R7 nodes hold while chain fills");
    copy_pulse();
    check_nodes(1, "R10 placement with gaps");

    // Chain moving again must not disturb the node registers (R7)
    send_range(2, 0, 7, 1'b0);
    idle();
    check_nodes(1, "R7 nodes hold while next block streams");

    // Unload (R8) with a load attempt mid-stream (R9)
    for (int k = 0; k < NRES; k++) rd[k*DW +: DW] = pval(9, k);
    @(negedge clk);
    rl = 1'b1;
    @(negedge clk);
    rl = 1'b0;
    for (int k = 0; k < NRES; k++) begin
      chk(rv == 1'b1, "R8 valid during unload", int'(rv), 1);
      chk(rp == pval(9, k), "R8/R9 unload pixel", int'(rp), int'(pval(9, k)));
      if (k == 2) begin
        rl = 1'b1;
        for (int j = 0; j < NRES; j++) rd[j*DW +: DW] = pval(5, j);
      end
      if (k == 3) rl = 1'b0;
      @(negedge clk);
    end
    chk(rv == 1'b0, "R8 valid ends after NW*NH", int'(rv), 0);

    // Neighbourhood depth zero instance (R2, R3)
    for (int k = 0; k < TOT0; k++) begin
      if (k == TOT0 - 1) begin
        @(negedge clk);
        pv0 = 1'b0;
        chk(full0 == 1'b0, "R2 depth0 not full one short", int'(full0), 0);
      end
      @(negedge clk);
      pv0 = 1'b1;
      pd0 = pval(4, TOT0 - 1 - k);
    end
    @(negedge clk);
    pv0 = 1'b0;
    chk(full0 == 1'b1, "R2 depth0 full at NW*NH", int'(full0), 1);
    @(negedge clk);
    cp0 = 1'b1;
    @(negedge clk);
    cp0 = 1'b0;
    for (int i = 0; i < TOT0; i++)
      chk(npx0[i*DW +: DW] == pval(4, i), "R3 depth0 placement",
          int'(npx0[i*DW +: DW]), int'(pval(4, i)));

    summary();
    $finish;
  end
endmodule